// File: doc/BRIEF.md
# Guarded Token Selector

This block is a small dataflow actor with two input streams and one output stream. One input carries a block kind code, the other carries data values. Values arrive in blocks of a fixed length, 64 by default. At the head of each block the actor takes one kind token together with the first value, and forwards that value only when the kind equals a configured code. It takes every later value of the block from the value stream and discards it, and it leaves the kind stream alone until the next head.

Three guarded actions carry out this behaviour: forward-head, skip-head and drain-body. A combinational scheduler looks at the kind token at the head of its queue without taking it. It also checks which tokens are present, the output's readiness and the block position. It then raises exactly one go line. The chosen action finishes its handshakes and returns done in the same cycle. The position tracker is a two-state machine (`PH_HEAD`, `PH_BODY`) with a position counter. Its transitions are: head to body on the done of forward-head or skip-head, body to body on a drain-body done below the last position, and body to head on a drain-body done at the last position. The counter value that a guard reads is always the value from before the action fires.

Top module: `tsel_top`

## Requirements
- R1: While reset is asserted, kind_ready, val_ready and out_valid are all low. After reset the block is at the head of a block, with position 0.
- R2: At a head, when kind_valid and val_valid are high, kind_data equals FWD_KIND (default 1) and out_ready is high, both input tokens are taken in that cycle, out_valid is high and out_data equals val_data.
- R3: At a head whose kind_data differs from FWD_KIND, both input tokens are taken in the cycle in which both are valid, and out_valid stays low, whatever out_ready is.
- R4: At positions 1 to BLOCK_LEN-1, kind_ready and out_valid stay low, and each valid value token is taken.
- R5: A block is exactly BLOCK_LEN value tokens long. After the last of them the block is at a head again, so a value token alone is not taken.
- R6: When no guard holds, no token is taken and the position holds. Examples are a head with only one of the two inputs valid, or a body cycle without a value token.
- R7: A head that would forward waits, taking nothing, while out_ready is low. Skip-head and drain-body go ahead while out_ready is low.
- R8: When tokens are always present, one action fires in every clock cycle.
- R9: In any cycle at most one action is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kind_valid | input | 1 | Kind token present |
| kind_ready | output | 1 | Kind token taken this cycle |
| kind_data | input | KIND_W | Block kind code |
| val_valid | input | 1 | Value token present |
| val_ready | output | 1 | Value token taken this cycle |
| val_data | input | DATA_W | Value payload |
| out_valid | output | 1 | Forwarded value present |
| out_ready | input | 1 | Consumer accepts the output |
| out_data | output | DATA_W | Forwarded value |

## Verification
The properties assume the valid/ready convention on the inputs: a token counts as taken only in a cycle where its valid and the matching ready are both high. They also assume that kind_data is stable whenever kind_valid is high. The stimulus changes inputs only on the falling clock edge and holds each token until the bench has seen it taken. It raises the kind stream in body cycles with a deliberately different code, to show that those tokens are left untouched. It forwards a kind that matches FWD_KIND only while the output can accept, apart from one deliberate stall that is held and then released.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
    localparam int ACT_KEEP  = 0;
    localparam int ACT_SKIP  = 1;
    localparam int ACT_DRAIN = 2;
    localparam int N_ACT     = 3;

    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_BODY = 1'b1
    } phase_t;
endpackage

// File: rtl/tsel_sched.sv
module tsel_sched
    import tsel_pkg::*;
#(
    parameter int KIND_W   = 8,
    parameter int FWD_KIND = 1
) (
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              kind_valid,
    input  logic [KIND_W-1:0] kind_data,
    input  logic              val_valid,
    input  logic              out_ready,
    output logic [N_ACT-1:0]  go
);
    localparam logic [KIND_W-1:0] FWD_CODE = KIND_W'(FWD_KIND);

    logic at_head;
    logic kind_match;
    logic both_in;

    always_comb begin
        at_head    = (phase == PH_HEAD);
        kind_match = (kind_data == FWD_CODE);
        both_in    = kind_valid && val_valid;
    end

    always_comb begin
        go = '0;
        if (rst_n) begin
            unique case (phase)
                PH_HEAD: begin
                    if (both_in && kind_match && out_ready)
                        go[ACT_KEEP] = 1'b1;
                    else if (both_in && !kind_match)
                        go[ACT_SKIP] = 1'b1;
                end
                PH_BODY: begin
                    if (val_valid)
                        go[ACT_DRAIN] = 1'b1;
                end
                default: go = '0;
            endcase
        end
    end
endmodule

// File: rtl/tsel_actions.sv
module tsel_actions
    import tsel_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [N_ACT-1:0]  go,
    input  logic              kind_valid,
    input  logic              val_valid,
    input  logic [DATA_W-1:0] val_data,
    input  logic              out_ready,
    output logic              kind_ready,
    output logic              val_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [N_ACT-1:0]  done
);
    always_comb begin
        kind_ready = go[ACT_KEEP] || go[ACT_SKIP];
        val_ready  = |go;
        out_valid  = go[ACT_KEEP];
        out_data   = val_data;
    end

    always_comb begin
        done[ACT_KEEP]  = go[ACT_KEEP] && kind_valid && val_valid && out_ready;
        done[ACT_SKIP]  = go[ACT_SKIP] && kind_valid && val_valid;
        done[ACT_DRAIN] = go[ACT_DRAIN] && val_valid;
    end
endmodule

// File: rtl/tsel_pos.sv
module tsel_pos
    import tsel_pkg::*;
#(
    parameter int BLOCK_LEN = 64,
    parameter int CNT_W     = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ACT-1:0] done,
    output phase_t           phase,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_LEN - 1);

    phase_t           phase_nx;
    logic [CNT_W-1:0] count_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_HEAD;
            count <= '0;
        end else begin
            phase <= phase_nx;
            count <= count_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        count_nx = count;
        unique case (phase)
            PH_HEAD: begin
                if (done[ACT_KEEP] || done[ACT_SKIP]) begin
                    phase_nx = PH_BODY;
                    count_nx = CNT_W'(1);
                end
            end
            PH_BODY: begin
                if (done[ACT_DRAIN]) begin
                    if (count == LAST) begin
                        phase_nx = PH_HEAD;
                        count_nx = '0;
                    end else begin
                        count_nx = count + CNT_W'(1);
                    end
                end
            end
            default: begin
                phase_nx = PH_HEAD;
                count_nx = '0;
            end
        endcase
    end
endmodule

// File: rtl/tsel_top.sv
module tsel_top
    import tsel_pkg::*;
#(
    parameter int KIND_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BLOCK_LEN = 64,
    parameter int FWD_KIND  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kind_valid,
    output logic              kind_ready,
    input  logic [KIND_W-1:0] kind_data,
    input  logic              val_valid,
    output logic              val_ready,
    input  logic [DATA_W-1:0] val_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int CNT_W = $clog2(BLOCK_LEN);

    phase_t           phase;
    logic [CNT_W-1:0] count;
    logic [N_ACT-1:0] go;
    logic [N_ACT-1:0] done;

    tsel_sched #(.KIND_W(KIND_W), .FWD_KIND(FWD_KIND)) u_sched (
        .rst_n      (rst_n),
        .phase      (phase),
        .kind_valid (kind_valid),
        .kind_data  (kind_data),
        .val_valid  (val_valid),
        .out_ready  (out_ready),
        .go         (go)
    );

    tsel_actions #(.DATA_W(DATA_W)) u_act (
        .go         (go),
        .kind_valid (kind_valid),
        .val_valid  (val_valid),
        .val_data   (val_data),
        .out_ready  (out_ready),
        .kind_ready (kind_ready),
        .val_ready  (val_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .done       (done)
    );

    tsel_pos #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .phase (phase),
        .count (count)
    );
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk
    import tsel_pkg::*;
#(
    parameter int KIND_W    = 8,
    parameter int CNT_W     = 6,
    parameter int BLOCK_LEN = 64,
    parameter int FWD_KIND  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kind_valid,
    input logic              kind_ready,
    input logic [KIND_W-1:0] kind_data,
    input logic              val_valid,
    input logic              val_ready,
    input logic              out_valid,
    input logic              out_ready,
    input phase_t            phase,
    input logic [CNT_W-1:0]  count,
    input logic [N_ACT-1:0]  go
);
    localparam logic [CNT_W-1:0]  LAST     = CNT_W'(BLOCK_LEN - 1);
    localparam logic [KIND_W-1:0] FWD_CODE = KIND_W'(FWD_KIND);

    assert_forward_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (kind_valid && kind_ready && val_ready && kind_data == FWD_CODE && count == '0));

    assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_ready && kind_data != FWD_CODE) |-> !out_valid);

    assert_body_kind_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (!kind_ready && !out_valid));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == LAST && val_valid && val_ready) |=> (count == '0 && phase == PH_HEAD));

    assert_phase_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HEAD) == (count == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(val_valid && val_ready) |=> $stable(count));

    assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ready);

    assert_body_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && val_valid) |-> val_ready);

    assert_single_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go));
endmodule

bind tsel_top tsel_chk #(
    .KIND_W(KIND_W), .CNT_W(CNT_W), .BLOCK_LEN(BLOCK_LEN), .FWD_KIND(FWD_KIND)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind_valid (kind_valid),
    .kind_ready (kind_ready),
    .kind_data  (kind_data),
    .val_valid  (val_valid),
    .val_ready  (val_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .phase      (phase),
    .count      (count),
    .go         (go)
);

// File: tb/tsel_top_test.sv
module tsel_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int KW  = 8;
    localparam int DW  = 16;
    localparam int BL  = 64;
    localparam int FWD = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kind_valid = 1'b0;
    logic          kind_ready;
    logic [KW-1:0] kind_data = '0;
    logic          val_valid = 1'b0;
    logic          val_ready;
    logic [DW-1:0] val_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] sb_q[$];
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsel_top #(.KIND_W(KW), .DATA_W(DW), .BLOCK_LEN(BL), .FWD_KIND(FWD)) uut (
        .clk(clk), .rst_n(rst_n),
        .kind_valid(kind_valid), .kind_ready(kind_ready), .kind_data(kind_data),
        .val_valid(val_valid), .val_ready(val_ready), .val_data(val_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] flags();
        return {kind_ready, val_ready, out_valid, 1'b0};
    endfunction

    // Monitor: scoreboard of forwarded values
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/2 - 1);
            if (rst_n && out_valid && out_ready) begin
                if (sb_q.size() == 0)
                    check(1'b0, "R3 unexpected output", 32'(out_data), 32'hFFFF_FFFF);
                else begin
                    logic [DW-1:0] e;
                    e = sb_q.pop_front();
                    check(out_data == e, "R2 forwarded value", 32'(out_data), 32'(e));
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        kind_valid = 1'b0; val_valid = 1'b0; out_ready = 1'b1;
    endtask

    task automatic run_block(input logic [KW-1:0] k, input logic [DW-1:0] v0,
                             input bit head_ordy, input bit body_ordy, input int gap);
        @(negedge clk);
        kind_valid = 1'b1; kind_data = k; val_valid = 1'b1; val_data = v0; out_ready = head_ordy;
        #1;
        if (k == KW'(FWD)) begin
            sb_q.push_back(v0);
            check(kind_ready && val_ready && out_valid, "R2 forward head", 32'(flags()), 32'hE);
        end else begin
            check(kind_ready && val_ready && !out_valid, "R3 skip head", 32'(flags()), 32'hC);
        end
        for (int i = 1; i < BL; i++) begin
            if (gap > 0 && (i % gap) == 0) begin
                @(negedge clk);
                val_valid = 1'b0; kind_valid = 1'b1; kind_data = k ^ KW'(1);
                #1;
                check(!val_ready && !kind_ready, "R6 body idle", 32'(flags()), 32'h0);
            end
            @(negedge clk);
            val_valid = 1'b1; val_data = v0 + DW'(i);
            kind_valid = 1'b1; kind_data = KW'(FWD);
            out_ready = body_ordy;
            #1;
            check(val_ready && !kind_ready && !out_valid, "R4/R8 drain body", 32'(flags()), 32'h4);
        end
        @(negedge clk);
        kind_valid = 1'b0; val_valid = 1'b1; val_data = 16'hDEAD; out_ready = 1'b1;
        #1;
        check(!val_ready && !out_valid, "R5 block length", 32'(flags()), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset holds off all handshakes
        kind_valid = 1'b1; kind_data = KW'(FWD); val_valid = 1'b1; val_data = 16'h0BAD; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!kind_ready && !val_ready && !out_valid, "R1 reset quiet", 32'(flags()), 32'h0);
        @(negedge clk);
        kind_valid = 1'b0; val_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset a lone value is not taken (head expects both)
        @(negedge clk);
        val_valid = 1'b1;
        #1;
        check(!val_ready, "R1 head after reset", 32'(val_ready), 32'h0);

        // R2 R4 R5 R8: forward block, continuous tokens
        run_block(KW'(FWD), 16'h1000, 1'b1, 1'b1, 0);
        // R3 R7: skip head and body with output blocked
        run_block(KW'(5), 16'h2000, 1'b0, 1'b0, 0);

        // R6: head with only one input valid
        @(negedge clk);
        kind_valid = 1'b0; val_valid = 1'b1; kind_data = KW'(FWD); out_ready = 1'b1;
        #1;
        check(!val_ready && !kind_ready, "R6 value only at head", 32'(flags()), 32'h0);
        @(negedge clk);
        kind_valid = 1'b1; val_valid = 1'b0;
        #1;
        check(!val_ready && !kind_ready, "R6 kind only at head", 32'(flags()), 32'h0);
        run_block(KW'(FWD), 16'h3000, 1'b1, 1'b1, 7);

        // R7: forward head stalls while output blocked
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            kind_valid = 1'b1; kind_data = KW'(FWD); val_valid = 1'b1; val_data = 16'h4444; out_ready = 1'b0;
            #1;
            check(!kind_ready && !val_ready && !out_valid, "R7 forward stall", 32'(flags()), 32'h0);
        end
        run_block(KW'(FWD), 16'h4000, 1'b1, 1'b0, 0);
        run_block(KW'(0), 16'h5000, 1'b1, 1'b1, 0);
        run_block(KW'(FWD), 16'h6000, 1'b1, 1'b1, 5);

        idle();
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2 all forwarded values seen", 32'(sb_q.size()), 32'h0);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule